// File: doc/BRIEF.md
# Readout protection level controller

This block keeps the readout protection level of an on-chip flash controller. Option storage presents a protection key byte and a check byte. On every reload strobe, which marks the system reset that reloads option storage, the block decodes the pair into one of three levels. Level 0 is open. Level 1 blocks readout from outside user code. Level 2 is locked. The decode is asymmetric: only two exact pairs give level 0 or level 2, and every other pair, including an erased byte or a bad check byte, falls to level 1.

While running, the block filters every access to main flash, option storage, backup registers and the tightly coupled SRAM. The filter uses the active level, the execution context of the requester and the operation. At level 2 it also switches off the debug port, the RAM boot path and the system boot path.

Requests to program a new protection pair are checked against the active level. An accepted value waits in a shadow register until the next reload. A reload that takes level 1 down to level 0 first asks for a mass erase of main flash and waits for the erase engine to report completion. Any attempt to leave level 2 is refused.

Top module: `rdp_level_ctrl`

## Requirements
- R1: On a reload with no pending value, the pair (key, check) decodes to level 0 only for (0xAA, 0x55) and to level 2 only for (0xCC, 0x33). Every other pair decodes to level 1. The level is presented on `level_o` as 0, 1 or 2 in the cycle after the strobe.
- R2: After reset, `level_o` is 1 until the first reload. Changing the option pins without a reload strobe leaves `level_o` unchanged.
- R3: An accepted program request pulses `prog_ack_o` for one cycle, one cycle after the request. It does not change `level_o`. The next reload applies the pending level in place of the option pins and then discards the pending value.
- R4: While the active level is 2, a program request whose pair decodes to any level other than 2 pulses `prog_rej_o`. A request decoding to 2 is acknowledged.
- R5: Raising the level (0 to 1, 0 to 2, 1 to 2) through a program request followed by a reload is accepted and produces no erase request.
- R6: A reload that would move an already loaded level 1 to level 0 raises `erase_req_o` for exactly one cycle and raises `busy_o`. It keeps `level_o` at 1 until `erase_done_i` is sampled high. In the cycle after that, `level_o` becomes 0 and `busy_o` drops. This applies both to a pending value and to the option pins.
- R7: At level 0, every access in every context is granted, one cycle after the request, with neither `bus_err_o` nor `fault_o`.
- R8: At level 1, user flash-boot code may do any operation on all resources. Debug (ctx 1), RAM boot (ctx 2) and system boot (ctx 3) are refused on main flash (res 0), backup registers (res 2) and SRAM (res 3), but may still reach option storage (res 1). A refusal raises `bus_err_o`, and it raises `fault_o` too unless the context is debug. Grant and error are never raised together.
- R9: At level 2, `dbg_en_o`, `ram_boot_en_o` and `sys_boot_en_o` are low, and every access from a non-user context is refused. User code (ctx 0) keeps all operations on main flash, backup registers and SRAM, but only reads (op 0) on option storage. Program (op 1), erase (op 2) and the reserved op 3 are refused there. At levels 0 and 1 the three enables are high.
- R10: Once level 2 is loaded, a later reload keeps level 2 whatever the option pins hold, and raises no erase request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opt_key_i | input | 8 | Protection key byte from option storage |
| opt_chk_i | input | 8 | Check byte from option storage |
| reload_i | input | 1 | Option reload strobe (system reset reload) |
| prog_req_i | input | 1 | Request to program a new protection pair |
| prog_key_i | input | 8 | Requested key byte |
| prog_chk_i | input | 8 | Requested check byte |
| prog_ack_o | output | 1 | Program request accepted (one-cycle pulse) |
| prog_rej_o | output | 1 | Program request refused (one-cycle pulse) |
| erase_req_o | output | 1 | Mass erase request (one-cycle pulse) |
| erase_done_i | input | 1 | Mass erase finished |
| busy_o | output | 1 | Reload waiting for mass erase |
| level_o | output | 2 | Active level, 0 to 2 |
| acc_req_i | input | 1 | Access request valid |
| acc_ctx_i | input | 2 | Context: 0 user flash boot, 1 debug, 2 RAM boot, 3 system boot |
| acc_res_i | input | 2 | Resource: 0 main flash, 1 option storage, 2 backup registers, 3 SRAM |
| acc_op_i | input | 2 | Operation: 0 read, 1 program, 2 erase, 3 reserved (treated as write) |
| acc_grant_o | output | 1 | Access granted (one cycle after request) |
| bus_err_o | output | 1 | Access refused |
| fault_o | output | 1 | Refusal that faults the core (non-debug context) |
| dbg_en_o | output | 1 | Debug port enabled |
| ram_boot_en_o | output | 1 | RAM boot path enabled |
| sys_boot_en_o | output | 1 | System boot path enabled |

## Verification
The bench sweeps every key byte with its true complement, and every check byte against the two special keys. A decoder that looked only at the key byte would wrongly report level 0 or 2 for a bad check byte. The full context, resource and operation space is swept at each level. That exposes a filter that lets debug reach SRAM at level 1, or lets user code write option storage at level 2. The 1-to-0 reload is held across several cycles of pending erase: a design that switched the level early, or held the erase request longer than one cycle, is caught. The bench also reloads an open pair after locking, and tries to program an open or middle pair at level 2, to show that the lock is one-way.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef enum logic [1:0] {LVL0 = 2'd0, LVL1 = 2'd1, LVL2 = 2'd2} lvl_e;
  typedef enum logic [1:0] {CTX_USER = 2'd0, CTX_DEBUG = 2'd1, CTX_RAMBOOT = 2'd2, CTX_SYSBOOT = 2'd3} ctx_e;
  typedef enum logic [1:0] {RES_MAIN = 2'd0, RES_OPT = 2'd1, RES_BKP = 2'd2, RES_SRAM = 2'd3} res_e;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_RSVD = 2'd3} op_e;
endpackage

// File: rtl/rdp_rst_sync.sv
module rdp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rdp_decode.sv
module rdp_decode
  import rdp_pkg::*;
#(
  parameter int              KEY_W    = 8,
  parameter logic [KEY_W-1:0] OPEN_KEY = 8'hAA,
  parameter logic [KEY_W-1:0] LOCK_KEY = 8'hCC
) (
  input  logic [KEY_W-1:0] key_i,
  input  logic [KEY_W-1:0] chk_i,
  output lvl_e             lvl_o
);
  localparam logic [KEY_W-1:0] OPEN_CHK = ~OPEN_KEY;
  localparam logic [KEY_W-1:0] LOCK_CHK = ~LOCK_KEY;

  always_comb begin
    if (key_i == OPEN_KEY && chk_i == OPEN_CHK)      lvl_o = LVL0;
    else if (key_i == LOCK_KEY && chk_i == LOCK_CHK) lvl_o = LVL2;
    else                                             lvl_o = LVL1;
  end
endmodule

// File: rtl/rdp_change.sv
module rdp_change
  import rdp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic reload_i,
  input  lvl_e store_lvl_i,
  input  logic prog_req_i,
  input  lvl_e prog_lvl_i,
  input  logic erase_done_i,
  output lvl_e level_o,
  output logic busy_o,
  output logic erase_req_o,
  output logic prog_ack_o,
  output logic prog_rej_o
);
  typedef enum logic {ST_IDLE = 1'b0, ST_ERASE = 1'b1} st_e;

  st_e  state_q, state_d;
  lvl_e level_q, level_d, shadow_q, shadow_d, tgt;
  logic loaded_q, loaded_d, vld_q, vld_d;
  logic erase_q, erase_d, ack_q, ack_d, rej_q, rej_d;
  logic lvl_en, shadow_en, need_erase;

  always_comb begin
    tgt = vld_q ? shadow_q : store_lvl_i;
    if (loaded_q && level_q == LVL2) tgt = LVL2;
    need_erase = loaded_q && (level_q == LVL1) && (tgt == LVL0);

    state_d   = state_q;
    level_d   = level_q;
    shadow_d  = shadow_q;
    loaded_d  = loaded_q;
    vld_d     = vld_q;
    erase_d   = 1'b0;
    ack_d     = 1'b0;
    rej_d     = 1'b0;
    lvl_en    = 1'b0;
    shadow_en = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (reload_i) begin
          vld_d    = 1'b0;
          loaded_d = 1'b1;
          rej_d    = prog_req_i;
          if (need_erase) begin
            state_d = ST_ERASE;
            erase_d = 1'b1;
          end else begin
            level_d = tgt;
            lvl_en  = 1'b1;
          end
        end else if (prog_req_i) begin
          if (level_q == LVL2 && prog_lvl_i != LVL2) begin
            rej_d = 1'b1;
          end else begin
            ack_d     = 1'b1;
            shadow_d  = prog_lvl_i;
            shadow_en = 1'b1;
            vld_d     = 1'b1;
          end
        end
      end
      default: begin
        rej_d = prog_req_i;
        if (erase_done_i) begin
          level_d = LVL0;
          lvl_en  = 1'b1;
          state_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      level_q  <= LVL1;
      shadow_q <= LVL1;
      loaded_q <= 1'b0;
      vld_q    <= 1'b0;
      erase_q  <= 1'b0;
      ack_q    <= 1'b0;
      rej_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      loaded_q <= loaded_d;
      vld_q    <= vld_d;
      erase_q  <= erase_d;
      ack_q    <= ack_d;
      rej_q    <= rej_d;
      if (lvl_en)    level_q  <= level_d;
      if (shadow_en) shadow_q <= shadow_d;
    end
  end

  assign level_o     = level_q;
  assign busy_o      = (state_q == ST_ERASE);
  assign erase_req_o = erase_q;
  assign prog_ack_o  = ack_q;
  assign prog_rej_o  = rej_q;

  // R6
  erase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req_o |=> !erase_req_o);
  // R6
  erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (level_q == LVL1));
  // R3
  mid_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_i && !busy_o) |=> $stable(level_q));
  // R10
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && level_q == LVL2) |=> (level_q == LVL2));
  // R4
  lock_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req_i && !reload_i && !busy_o && level_q == LVL2 && prog_lvl_i != LVL2) |=> prog_rej_o);
  // R3
  ack_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_ack_o && prog_rej_o));
endmodule

// File: rtl/rdp_gate.sv
module rdp_gate
  import rdp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  lvl_e level_i,
  input  logic req_i,
  input  ctx_e ctx_i,
  input  res_e res_i,
  input  op_e  op_i,
  output logic grant_o,
  output logic err_o,
  output logic fault_o,
  output logic dbg_en_o,
  output logic ram_en_o,
  output logic sys_en_o
);
  logic allow, grant_d, err_d, fault_d;
  logic grant_q, err_q, fault_q;

  always_comb begin
    case (level_i)
      LVL0:    allow = 1'b1;
      LVL1:    allow = (ctx_i == CTX_USER) || (res_i == RES_OPT);
      default: allow = (ctx_i == CTX_USER) && ((res_i != RES_OPT) || (op_i == OP_READ));
    endcase
    grant_d = req_i && allow;
    err_d   = req_i && !allow;
    fault_d = err_d && (ctx_i != CTX_DEBUG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      err_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      grant_q <= grant_d;
      err_q   <= err_d;
      fault_q <= fault_d;
    end
  end

  assign grant_o  = grant_q;
  assign err_o    = err_q;
  assign fault_o  = fault_q;
  assign dbg_en_o = (level_i != LVL2);
  assign ram_en_o = (level_i != LVL2);
  assign sys_en_o = (level_i != LVL2);

  // R7
  open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && level_i == LVL0) |=> (grant_o && !err_o && !fault_o));
  // R8
  l1_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && level_i == LVL1 && ctx_i != CTX_USER && res_i != RES_OPT) |=> err_o);
  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_o, err_o}));
  // R9
  l2_opt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && level_i == LVL2 && res_i == RES_OPT && op_i != OP_READ) |=> (err_o && !grant_o));
endmodule

// File: rtl/rdp_level_ctrl.sv
module rdp_level_ctrl
  import rdp_pkg::*;
#(
  parameter int               KEY_W    = 8,
  parameter logic [KEY_W-1:0] OPEN_KEY = 8'hAA,
  parameter logic [KEY_W-1:0] LOCK_KEY = 8'hCC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] opt_key_i,
  input  logic [KEY_W-1:0] opt_chk_i,
  input  logic             reload_i,
  input  logic             prog_req_i,
  input  logic [KEY_W-1:0] prog_key_i,
  input  logic [KEY_W-1:0] prog_chk_i,
  output logic             prog_ack_o,
  output logic             prog_rej_o,
  output logic             erase_req_o,
  input  logic             erase_done_i,
  output logic             busy_o,
  output logic [1:0]       level_o,
  input  logic             acc_req_i,
  input  logic [1:0]       acc_ctx_i,
  input  logic [1:0]       acc_res_i,
  input  logic [1:0]       acc_op_i,
  output logic             acc_grant_o,
  output logic             bus_err_o,
  output logic             fault_o,
  output logic             dbg_en_o,
  output logic             ram_boot_en_o,
  output logic             sys_boot_en_o
);
  logic rst_int_n;
  lvl_e store_lvl, prog_lvl, level;

  rdp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  rdp_decode #(.KEY_W(KEY_W), .OPEN_KEY(OPEN_KEY), .LOCK_KEY(LOCK_KEY)) u_dec_store (
    .key_i(opt_key_i), .chk_i(opt_chk_i), .lvl_o(store_lvl)
  );

  rdp_decode #(.KEY_W(KEY_W), .OPEN_KEY(OPEN_KEY), .LOCK_KEY(LOCK_KEY)) u_dec_prog (
    .key_i(prog_key_i), .chk_i(prog_chk_i), .lvl_o(prog_lvl)
  );

  rdp_change u_change (
    .clk(clk), .rst_n(rst_int_n), .reload_i(reload_i), .store_lvl_i(store_lvl),
    .prog_req_i(prog_req_i), .prog_lvl_i(prog_lvl), .erase_done_i(erase_done_i),
    .level_o(level), .busy_o(busy_o), .erase_req_o(erase_req_o),
    .prog_ack_o(prog_ack_o), .prog_rej_o(prog_rej_o)
  );

  rdp_gate u_gate (
    .clk(clk), .rst_n(rst_int_n), .level_i(level), .req_i(acc_req_i),
    .ctx_i(ctx_e'(acc_ctx_i)), .res_i(res_e'(acc_res_i)), .op_i(op_e'(acc_op_i)),
    .grant_o(acc_grant_o), .err_o(bus_err_o), .fault_o(fault_o),
    .dbg_en_o(dbg_en_o), .ram_en_o(ram_boot_en_o), .sys_en_o(sys_boot_en_o)
  );

  assign level_o = level;
endmodule

// File: tb/sim_rdp_level_ctrl.sv
`timescale 1ns/1ps
module sim_rdp_level_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] opt_key = 8'hFF, opt_chk = 8'hFF, prog_key = 8'h00, prog_chk = 8'h00;
  logic reload = 1'b0, prog_req = 1'b0, erase_done = 1'b0, acc_req = 1'b0;
  logic [1:0] acc_ctx = 2'd0, acc_res = 2'd0, acc_op = 2'd0;
  logic prog_ack, prog_rej, erase_req, busy, grant, berr, fault, dbg_en, ram_en, sys_en;
  logic [1:0] level;
  int total = 0, failed = 0;
  logic s_ack, s_rej;

  always #10 clk = ~clk;

  rdp_level_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .opt_key_i(opt_key), .opt_chk_i(opt_chk), .reload_i(reload),
    .prog_req_i(prog_req), .prog_key_i(prog_key), .prog_chk_i(prog_chk),
    .prog_ack_o(prog_ack), .prog_rej_o(prog_rej), .erase_req_o(erase_req),
    .erase_done_i(erase_done), .busy_o(busy), .level_o(level),
    .acc_req_i(acc_req), .acc_ctx_i(acc_ctx), .acc_res_i(acc_res), .acc_op_i(acc_op),
    .acc_grant_o(grant), .bus_err_o(berr), .fault_o(fault),
    .dbg_en_o(dbg_en), .ram_boot_en_o(ram_en), .sys_boot_en_o(sys_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic do_reload(input logic [7:0] k, input logic [7:0] c);
    opt_key = k; opt_chk = c; reload = 1'b1;
    step();
    reload = 1'b0;
  endtask

  task automatic do_prog(input logic [7:0] k, input logic [7:0] c);
    prog_key = k; prog_chk = c; prog_req = 1'b1;
    step();
    prog_req = 1'b0;
    s_ack = prog_ack; s_rej = prog_rej;
  endtask

  function automatic int dec(input int k, input int c);
    if (k == 8'hAA && c == 8'h55) return 0;
    if (k == 8'hCC && c == 8'h33) return 2;
    return 1;
  endfunction

  function automatic int allowed(input int lv, input int cx, input int rs, input int op);
    if (lv == 0) return 1;
    if (lv == 1) return (cx == 0 || rs == 1) ? 1 : 0;
    return (cx == 0 && (rs != 1 || op == 0)) ? 1 : 0;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    do_reset();
    // R2 reset state
    chk("R2 level after reset", level, 1);
    chk("R2 busy after reset", busy, 0);
    chk("R2 erase after reset", erase_req, 0);
    opt_key = 8'hAA; opt_chk = 8'h55;
    repeat (3) step();
    chk("R2 no reload no change", level, 1);

    // R1 sweep: true complements
    for (int k = 0; k < 256; k++) begin
      do_reset();
      do_reload(8'(k), 8'(~k));
      chk("R1 key sweep", level, dec(k, 8'(~k)));
    end
    // R1 sweep: wrong check bytes against special keys
    for (int c = 0; c < 256; c++) begin
      do_reset();
      do_reload(8'hAA, 8'(c));
      chk("R1 open key check sweep", level, dec(8'hAA, c));
      do_reset();
      do_reload(8'hCC, 8'(c));
      chk("R1 lock key check sweep", level, dec(8'hCC, c));
    end

    // R7 R8 R9 access sweep per level
    for (int lv = 0; lv < 3; lv++) begin
      do_reset();
      if (lv == 0) do_reload(8'hAA, 8'h55);
      else if (lv == 1) do_reload(8'hBB, 8'h44);
      else do_reload(8'hCC, 8'h33);
      chk("R9 level set", level, lv);
      chk("R9 debug enable", dbg_en, lv != 2);
      chk("R9 ram boot enable", ram_en, lv != 2);
      chk("R9 sys boot enable", sys_en, lv != 2);
      for (int cx = 0; cx < 4; cx++)
        for (int rs = 0; rs < 4; rs++)
          for (int op = 0; op < 4; op++) begin
            int a;
            a = allowed(lv, cx, rs, op);
            acc_ctx = 2'(cx); acc_res = 2'(rs); acc_op = 2'(op); acc_req = 1'b1;
            step();
            acc_req = 1'b0;
            if (lv == 0) begin
              chk("R7 grant", grant, a);
              chk("R7 err", berr, 1 - a);
            end else if (lv == 1) begin
              chk("R8 grant", grant, a);
              chk("R8 err", berr, 1 - a);
              chk("R8 fault", fault, (a == 0 && cx != 1) ? 1 : 0);
            end else begin
              chk("R9 grant", grant, a);
              chk("R9 err", berr, 1 - a);
              chk("R9 fault", fault, (a == 0 && cx != 1) ? 1 : 0);
            end
          end
      step();
      chk("R8 idle no grant", grant, 0);
      chk("R8 idle no err", berr, 0);
    end

    // R3 R6 lowering 1 to 0 via pending value
    do_reset();
    do_reload(8'hBB, 8'h44);
    do_prog(8'hAA, 8'h55);
    chk("R3 ack", s_ack, 1);
    chk("R3 no rej", s_rej, 0);
    step();
    chk("R3 ack single", prog_ack, 0);
    chk("R3 level held", level, 1);
    do_reload(8'hBB, 8'h44);
    chk("R6 erase pulse", erase_req, 1);
    chk("R6 busy", busy, 1);
    chk("R6 level still 1", level, 1);
    step();
    chk("R6 erase one cycle", erase_req, 0);
    repeat (4) step();
    chk("R6 still busy", busy, 1);
    chk("R6 level held during erase", level, 1);
    erase_done = 1'b1;
    step();
    erase_done = 1'b0;
    chk("R6 level 0 after erase", level, 0);
    chk("R6 busy drops", busy, 0);
    // R3 pending value discarded: storage pair now applies
    do_reload(8'hCC, 8'h33);
    chk("R3 shadow cleared", level, 2);

    // R6 lowering via option pins
    do_reset();
    do_reload(8'h12, 8'h34);
    do_reload(8'hAA, 8'h55);
    chk("R6 pins erase", erase_req, 1);
    chk("R6 pins level", level, 1);
    step();
    erase_done = 1'b1;
    step();
    erase_done = 1'b0;
    chk("R6 pins level 0", level, 0);

    // R5 raises
    do_reset();
    do_reload(8'hAA, 8'h55);
    do_prog(8'hBB, 8'h44);
    chk("R5 0to1 ack", s_ack, 1);
    do_reload(8'hAA, 8'h55);
    chk("R5 0to1 level", level, 1);
    chk("R5 0to1 no erase", erase_req, 0);
    do_prog(8'hCC, 8'h33);
    chk("R5 1to2 ack", s_ack, 1);
    do_reload(8'hBB, 8'h44);
    chk("R5 1to2 level", level, 2);
    chk("R5 1to2 no erase", erase_req, 0);
    do_reset();
    do_reload(8'hAA, 8'h55);
    do_prog(8'hCC, 8'h33);
    do_reload(8'hAA, 8'h55);
    chk("R5 0to2 level", level, 2);
    chk("R5 0to2 no erase", erase_req, 0);

    // R4 leaving level 2 refused
    do_prog(8'hAA, 8'h55);
    chk("R4 to 0 rej", s_rej, 1);
    chk("R4 to 0 no ack", s_ack, 0);
    do_prog(8'hBB, 8'h44);
    chk("R4 to 1 rej", s_rej, 1);
    do_prog(8'hCC, 8'h33);
    chk("R4 stay 2 ack", s_ack, 1);
    chk("R4 stay 2 no rej", s_rej, 0);

    // R10 reload with open pins keeps level 2
    do_reload(8'hAA, 8'h55);
    chk("R10 level kept", level, 2);
    chk("R10 no erase", erase_req, 0);
    chk("R10 not busy", busy, 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule